// File: doc/BRIEF.md
# Speculative Load Fault Deferral Resolver

This block takes one load at a time, together with the memory fault conditions already found for it, and decides which fault reaches the trap logic. Some faults may instead be deferred, which means the load's destination register receives the Not-a-Thing (NaT) token rather than data. There are five fault classes. Each class has its own deferral enable in a small control register. A class is deferred only when the load is speculative, the load is not running in the legacy 32-bit mode, the code page permits deferral, and that class's enable is set.

The classes are checked in a fixed priority order. When a higher class is deferred, the first lower class that is not deferred is still delivered. A pending key-miss fault always removes a concurrent key-permission fault. This holds whether the key-miss fault is deferred or delivered. The decision is registered, so the delivered-fault vector and the NaT strobe appear one cycle after the request strobe.

Top module: `spec_defer_resolver`

## Requirements
- R1: After reset, `rspValid`, `rspFault` and `rspNatWrite` are 0, and `cfgRdData` reads 0.
- R2: A write through `cfgWrEn` stores only bits 14:10 of `cfgWrData`. Every other bit of `cfgRdData` reads 0. The new value is visible from the next cycle. A request made in the same cycle as the write uses the old value.
- R3: `rspValid` is `reqValid` delayed by one cycle. When `rspValid` is 0, `rspFault` and `rspNatWrite` are 0.
- R4: Fault vectors use this encoding: bit 0 is key miss (highest priority), bit 1 is key permission, bit 2 is access rights, bit 3 is access bit, and bit 4 is debug (lowest). `rspFault` has at most one bit set. That bit is the highest-priority pending class that is not deferred.
- R5: Class i is deferred only when all of the following hold: `reqSpec` is 1, `reqLegacy` is 0, `reqPageDefer` is 1, and control bit 10+i is 1.
- R6: For a non-speculative load, the highest-priority pending fault is always delivered and `rspNatWrite` stays 0.
- R7: For a load in legacy mode (`reqLegacy`=1), the control bits are ignored, and the load behaves as a non-speculative load.
- R8: When key miss (bit 0) is pending, a key-permission fault (bit 1) is never delivered and never causes a NaT write.
- R9: `rspNatWrite` is 1 when at least one pending class is deferred and lies above the delivered class. If no class is delivered, any deferred pending class sets it.
- R10: When `reqPageDefer` is 0, no class is deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 64 | Control register write data |
| cfgRdData | output | 64 | Control register contents; reserved bits read as zero |
| reqValid | input | 1 | Request strobe for one load |
| reqSpec | input | 1 | The load is speculative |
| reqLegacy | input | 1 | The load runs in legacy 32-bit mode |
| reqPageDefer | input | 1 | Exception-deferral bit of the code page |
| reqFaults | input | 5 | Pending fault classes; bit 0 has the highest priority |
| rspValid | output | 1 | Response valid, one cycle after `reqValid` |
| rspFault | output | 5 | One-hot delivered fault, or zero |
| rspNatWrite | output | 1 | Write the NaT token to the load's target register |

## Verification
The hardest case to reach from the ports is a chain of deferral and delivery in one request. For example, key miss is deferred, the key-permission fault is dropped, and the access-rights fault below it is still delivered with a NaT write. To reach it, the stimulus first writes a control value that enables only the key-miss class. It then issues speculative loads with several classes pending at once. The stimulus also mixes reserved-bit garbage into the control writes, and it places a request in the same cycle as a write, so that the old control value must still apply.

// File: rtl/spec_defer_pkg.sv
package spec_defer_pkg;
  localparam int NUM_CLASSES = 5;
  localparam int CFG_WIDTH   = 64;
  localparam int DEFER_LSB   = 10;

  localparam int CLS_KEY_MISS = 0;
  localparam int CLS_KEY_PERM = 1;

  typedef logic [NUM_CLASSES-1:0] classVec_t;

  typedef struct packed {
    logic      capture;
    classVec_t deferEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/defer_ctrl.sv
module defer_ctrl
  import spec_defer_pkg::*;
#(
  parameter int CfgWidth = CFG_WIDTH,
  parameter int DeferLsb = DEFER_LSB
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [CfgWidth-1:0] cfgWrData,
  input  logic                reqValid,
  input  logic                reqSpec,
  input  logic                reqLegacy,
  input  logic                reqPageDefer,
  output logic [CfgWidth-1:0] cfgRdData,
  output ctrlStrobe_t         strobe
);
  localparam int DeferMsb = DeferLsb + NUM_CLASSES - 1;

  classVec_t deferBits;
  logic      deferGate;

  // Only the deferral field is held; every other bit is dropped on write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        deferBits <= '0;
    else if (cfgWrEn) deferBits <= cfgWrData[DeferMsb:DeferLsb];
  end

  always_comb begin
    cfgRdData = '0;
    cfgRdData[DeferMsb:DeferLsb] = deferBits;
  end

  // Deferral needs speculation, non-legacy mode and page permission.
  assign deferGate = reqSpec & ~reqLegacy & reqPageDefer;

  always_comb begin
    strobe.capture = reqValid;
    strobe.deferEn = deferGate ? deferBits : '0;
  end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(cfgRdData));

  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData[DeferMsb:DeferLsb] == $past(cfgWrData[DeferMsb:DeferLsb]));
endmodule

// File: rtl/defer_datapath.sv
module defer_datapath
  import spec_defer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  classVec_t   reqFaults,
  output logic        rspValid,
  output classVec_t   rspFault,
  output logic        rspNatWrite
);
  classVec_t pending;
  classVec_t deferred;
  classVec_t taken;
  classVec_t blocked;
  classVec_t deliver;
  logic      natCand;

  // A key-miss fault removes a concurrent key-permission fault.
  always_comb begin
    pending = reqFaults;
    if (reqFaults[CLS_KEY_MISS]) pending[CLS_KEY_PERM] = 1'b0;
  end

  assign deferred = pending & strobe.deferEn;
  assign taken    = pending & ~strobe.deferEn;

  // blocked[i]: some class above i is taken as a fault.
  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_chain
    if (i == 0) begin : g_top
      assign blocked[i] = 1'b0;
    end else begin : g_rest
      assign blocked[i] = blocked[i-1] | taken[i-1];
    end
    assign deliver[i] = taken[i] & ~blocked[i];
  end

  assign natCand = |(deferred & ~blocked);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspFault    <= '0;
      rspNatWrite <= 1'b0;
    end else begin
      rspValid    <= strobe.capture;
      rspFault    <= strobe.capture ? deliver : '0;
      rspNatWrite <= strobe.capture & natCand;
    end
  end

  p_onehot_fault_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspFault));

  p_fault_was_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (rspFault & ~$past(reqFaults)) == '0);

  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspFault == '0 && !rspNatWrite));

  p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspValid);

  p_valid_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !rspValid);

  p_keyperm_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && reqFaults[CLS_KEY_MISS]) |=> !rspFault[CLS_KEY_PERM]);

  p_no_nat_without_defer_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.deferEn == '0) |=> !rspNatWrite);
endmodule

// File: rtl/spec_defer_resolver.sv
module spec_defer_resolver
  import spec_defer_pkg::*;
#(
  parameter int CfgWidth = CFG_WIDTH,
  parameter int DeferLsb = DEFER_LSB
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [CfgWidth-1:0]    cfgWrData,
  output logic [CfgWidth-1:0]    cfgRdData,
  input  logic                   reqValid,
  input  logic                   reqSpec,
  input  logic                   reqLegacy,
  input  logic                   reqPageDefer,
  input  logic [NUM_CLASSES-1:0] reqFaults,
  output logic                   rspValid,
  output logic [NUM_CLASSES-1:0] rspFault,
  output logic                   rspNatWrite
);
  ctrlStrobe_t strobe;

  defer_ctrl #(.CfgWidth(CfgWidth), .DeferLsb(DeferLsb)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .reqValid     (reqValid),
    .reqSpec      (reqSpec),
    .reqLegacy    (reqLegacy),
    .reqPageDefer (reqPageDefer),
    .cfgRdData    (cfgRdData),
    .strobe       (strobe)
  );

  defer_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqFaults   (reqFaults),
    .rspValid    (rspValid),
    .rspFault    (rspFault),
    .rspNatWrite (rspNatWrite)
  );
endmodule

// File: tb/spec_defer_resolver_bench.sv
module spec_defer_resolver_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [63:0] cfgWrData;
  logic [63:0] cfgRdData;
  logic        reqValid, reqSpec, reqLegacy, reqPageDefer;
  logic [4:0]  reqFaults;
  logic        rspValid;
  logic [4:0]  rspFault;
  logic        rspNatWrite;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [4:0] modelCfg;
  logic       expValid;
  logic [4:0] expFault;
  logic       expNat;
  string      expTag;

  always #10 clk = ~clk;

  spec_defer_resolver u_spec_defer_resolver (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqSpec(reqSpec),
    .reqLegacy(reqLegacy), .reqPageDefer(reqPageDefer), .reqFaults(reqFaults),
    .rspValid(rspValid), .rspFault(rspFault), .rspNatWrite(rspNatWrite)
  );

  // Scan the classes in priority order: deferred ones mark NaT, the first taken one is delivered.
  function automatic void model(input logic spec, input logic legacy, input logic page,
                                input logic [4:0] f, input logic [4:0] cfg,
                                output logic [4:0] dlv, output logic nat);
    logic [4:0] p;
    p = f;
    if (f[0]) p[1] = 1'b0;
    dlv = '0;
    nat = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (p[i]) begin
        if (spec && !legacy && page && cfg[i]) nat = 1'b1;
        else begin
          dlv[i] = 1'b1;
          break;
        end
      end
    end
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic wr, input logic [63:0] wd,
                      input logic v, input logic s, input logic l, input logic pg,
                      input logic [4:0] f);
    logic [4:0] dlv;
    logic       nat;
    @(negedge clk);
    check(expTag, "rspValid", {63'b0, rspValid}, {63'b0, expValid});
    check(expTag, "rspFault", {59'b0, rspFault}, {59'b0, expFault});
    check(expTag, "rspNatWrite", {63'b0, rspNatWrite}, {63'b0, expNat});
    check("R2", "cfgRdData", cfgRdData, {49'b0, modelCfg, 10'b0});
    cfgWrEn = wr; cfgWrData = wd;
    reqValid = v; reqSpec = s; reqLegacy = l; reqPageDefer = pg; reqFaults = f;
    model(s, l, pg, f, modelCfg, dlv, nat);
    expValid = v;
    expFault = v ? dlv : 5'b0;
    expNat   = v & nat;
    expTag   = tag;
    if (wr) modelCfg = wd[14:10];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 0; cfgWrData = '0;
    reqValid = 0; reqSpec = 0; reqLegacy = 0; reqPageDefer = 0; reqFaults = '0;
    modelCfg = '0; expValid = 0; expFault = '0; expNat = 0; expTag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    step("R1", 0, 64'h0, 0, 0, 0, 0, 5'b0);
    // R2: write all ones; a request in the same cycle still sees the old value
    step("R2", 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 1, 5'b00100);
    step("R5", 0, 64'h0, 1, 1, 0, 1, 5'b00101);
    step("R6", 0, 64'h0, 1, 0, 0, 1, 5'b11110);
    step("R7", 0, 64'h0, 1, 1, 1, 1, 5'b11000);
    step("R10", 0, 64'h0, 1, 1, 0, 0, 5'b10000);
    step("R2", 1, 64'h0000_0000_0000_0400, 0, 0, 0, 0, 5'b0);
    step("R8", 0, 64'h0, 1, 1, 0, 1, 5'b00111);
    step("R8", 0, 64'h0, 1, 1, 0, 1, 5'b00011);
    step("R2", 1, 64'hAAAA_AAAA_AAAA_1155, 0, 0, 0, 0, 5'b0);
    step("R9", 0, 64'h0, 1, 1, 0, 1, 5'b01100);
    step("R9", 0, 64'h0, 1, 1, 0, 1, 5'b01010);
    step("R3", 0, 64'h0, 0, 1, 0, 1, 5'b11111);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("R4", (r[3:0] == 4'd0), {$urandom, $urandom}, r[4], r[5], (r[8:6] == 3'd0),
           (r[10:9] != 2'd0), r[15:11]);
    end
    step("R3", 0, 64'h0, 0, 0, 0, 0, 5'b0);
    step("R3", 0, 64'h0, 0, 0, 0, 0, 5'b0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule